// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This unit is the register-move datapath of a processor core whose accumulator and index registers can each run 8 or 16 bits wide. It holds the accumulator, two index registers, the stack pointer, the direct-page base and the status bits that matter for moves. These are the two width selectors (accumulator width `m`, index width `x`), carry, negative, zero and the emulation bit. A single-cycle command port names one operation per clock. The unit updates the destination register and the flags, and one cycle later reports how many processor cycles the operation costs.

The operations are register-to-register transfers, an accumulator byte swap and an exchange of carry with the emulation bit. A load command writes any register or the status bits directly, so a sequencer (or a bench) can set up state. Every register and flag is visible on observation outputs. Fetch, memory, interrupts and arithmetic belong to other blocks.

Top module: `rxu_top`

## Requirements
- R1: After reset, A, X, Y and D read 0x0000, S reads 0x01FF, the emulation, m and x bits read 1, carry, n and z read 0, and rsp_valid and rsp_cycles read 0.
- R2: For A→X (op 1), A→Y (op 2), S→X (op 7), X→Y (op 10) and Y→X (op 12): with x=1 only the low byte of the destination changes, its high byte is kept, and n/z come from the 8-bit result. With x=0 all 16 bits are copied and n/z come from 16 bits.
- R3: For X→A (op 8) and Y→A (op 11): with m=1 only the accumulator low byte changes and n/z are 8-bit. With m=0 and x=1 the index low byte is zero-extended into A. With m=0 and x=0 the full index is copied. In both m=0 cases n/z come from 16 bits.
- R4: X→S (op 9) loads 0x01 into the stack high byte and X's low byte into the stack low byte when x=1, and copies X when x=0. A→S (op 4) copies all 16 bits. Neither changes n or z.
- R5: A→D (op 3), D→A (op 5) and S→A (op 6) move all 16 bits whatever m is, and set n/z from 16 bits.
- R6: The byte swap (op 13) exchanges the two bytes of A and sets n/z from the new low byte only.
- R7: The exchange (op 14) sets the emulation bit to the old carry and carry to the old emulation bit. When the emulation bit becomes 1, m and x are forced to 1 and the stack high byte to 0x01. While in emulation, any write to S leaves its high byte at 0x01, and a status load keeps m and x at 1.
- R8: n equals the top bit of the result at the active width, and z is 1 exactly when the result at that width is zero.
- R9: rsp_valid is 1 in the cycle after each accepted command and 0 after an idle cycle. rsp_cycles is 2 for transfers, the exchange and no-op (op 0), 3 for the byte swap, 1 for a load, and 0 with no response.
- R10: A load (op 15) writes cmd_data into A, X, Y, S or D for cmd_sel 0 to 4. For cmd_sel 5 it loads the status bits from cmd_data: bit 0 carry, bit 1 z, bit 4 x, bit 5 m, bit 7 n. For cmd_sel 6 and 7 it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | 3 | Load target selector |
| cmd_data | input | W | Load value |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_cycles | output | CW | Processor cycle cost of that command |
| obs_a | output | W | Accumulator |
| obs_x | output | W | X index register |
| obs_y | output | W | Y index register |
| obs_s | output | W | Stack pointer |
| obs_d | output | W | Direct-page base |
| flag_e | output | 1 | Emulation bit |
| flag_m | output | 1 | Accumulator width (1 = 8-bit) |
| flag_x | output | 1 | Index width (1 = 8-bit) |
| flag_c | output | 1 | Carry |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
The bench runs every transfer under all four m/x combinations with values such as 0x0080, 0x8000 and 0xFF00. These values put the 8-bit and 16-bit sign and zero results on opposite sides, so a design that takes n/z at the wrong width, or clobbers a kept high byte, shows up at once. Index-to-accumulator moves with m=0, x=1 catch a design that copies the stale index high byte instead of zero-extending. Exchanges into and out of emulation, followed by stack writes and status loads, catch a stack high byte that is not pinned or width bits that drop to 0 in emulation. The byte swap with a zero low and non-zero high byte catches z taken from the whole accumulator.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

   localparam int OPW   = 4;
   localparam int SELW  = 3;
   localparam int NREG  = 5;

   localparam int RI_A = 0;
   localparam int RI_X = 1;
   localparam int RI_Y = 2;
   localparam int RI_S = 3;
   localparam int RI_D = 4;
   localparam int SEL_FLAGS = 5;

   typedef enum logic [OPW-1:0] {
      OP_NOP  = 4'd0,
      OP_A2X  = 4'd1,
      OP_A2Y  = 4'd2,
      OP_A2D  = 4'd3,
      OP_A2S  = 4'd4,
      OP_D2A  = 4'd5,
      OP_S2A  = 4'd6,
      OP_S2X  = 4'd7,
      OP_X2A  = 4'd8,
      OP_X2S  = 4'd9,
      OP_X2Y  = 4'd10,
      OP_Y2A  = 4'd11,
      OP_Y2X  = 4'd12,
      OP_SWAP = 4'd13,
      OP_XCE  = 4'd14,
      OP_LOAD = 4'd15
   } rxu_op_e;

   typedef struct packed {
      logic e;
      logic m;
      logic x;
      logic c;
      logic n;
      logic z;
   } rxu_flags_t;

endpackage

// File: rtl/rxu_nz.sv
module rxu_nz #(
   parameter int W = 16,
   parameter int B = 8
) (
   input  logic [W-1:0] val,
   input  logic         wide,
   output logic         n,
   output logic         z
);

   always_comb begin
      if (wide) begin
         n = val[W-1];
         z = (val == '0);
      end else begin
         n = val[B-1];
         z = (val[B-1:0] == '0);
      end
   end

endmodule

// File: rtl/rxu_regfile.sv
module rxu_regfile
   import rxu_pkg::*;
#(
   parameter int W        = 16,
   parameter int B        = 8,
   parameter int NB       = W / B,
   parameter int STK_PAGE = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NREG-1:0]           dst,
   input  logic [NB-1:0]             lane,
   input  logic [W-1:0]              wdata,
   output logic [NREG-1:0][W-1:0]    q
);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      for (genvar l = 0; l < NB; l++) begin : g_lane
         localparam logic [B-1:0] RST_V =
            (r == RI_S) ? ((l == NB-1) ? B'(STK_PAGE) : {B{1'b1}}) : '0;
         logic [B-1:0] byte_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= RST_V;
            end else if (dst[r] && lane[l]) begin
               byte_q <= wdata[l*B +: B];
            end
         end

         assign q[r][l*B +: B] = byte_q;
      end
   end

endmodule

// File: rtl/rxu_exec.sv
module rxu_exec
   import rxu_pkg::*;
#(
   parameter int W        = 16,
   parameter int B        = 8,
   parameter int NB       = W / B,
   parameter int STK_PAGE = 1,
   parameter int CW       = 2,
   parameter int CYC_XFER = 2,
   parameter int CYC_SWAP = 3,
   parameter int CYC_LOAD = 1
) (
   input  logic              cmd_valid,
   input  logic [OPW-1:0]    cmd_op,
   input  logic [SELW-1:0]   cmd_sel,
   input  logic [W-1:0]      cmd_data,
   input  logic [W-1:0]      a_q,
   input  logic [W-1:0]      x_q,
   input  logic [W-1:0]      y_q,
   input  logic [W-1:0]      s_q,
   input  logic [W-1:0]      d_q,
   input  rxu_flags_t        fl_q,
   output logic [NREG-1:0]   dst,
   output logic [NB-1:0]     lane,
   output logic [W-1:0]      wdata,
   output rxu_flags_t        fl_d,
   output logic [CW-1:0]     cyc
);

   localparam logic [B-1:0]  STK      = B'(STK_PAGE);
   localparam logic [NB-1:0] LANE_LO  = NB'(1);
   localparam logic [NB-1:0] LANE_HI  = ~LANE_LO;
   localparam logic [NB-1:0] LANE_ALL = '1;

   logic [W-1:0] nz_src;
   logic         nz_wide;
   logic         nz_upd;
   logic         nz_n;
   logic         nz_z;
   rxu_flags_t   fb;

   always_comb begin
      dst     = '0;
      lane    = '0;
      wdata   = '0;
      nz_src  = '0;
      nz_wide = 1'b0;
      nz_upd  = 1'b0;
      fb      = fl_q;
      cyc     = CW'(CYC_XFER);
      if (cmd_valid) begin
         case (cmd_op)
            OP_A2X, OP_S2X, OP_Y2X: begin
               dst[RI_X] = 1'b1;
               wdata     = (cmd_op == OP_A2X) ? a_q :
                           (cmd_op == OP_S2X) ? s_q : y_q;
               lane      = fl_q.x ? LANE_LO : LANE_ALL;
               nz_src    = wdata;
               nz_wide   = !fl_q.x;
               nz_upd    = 1'b1;
            end
            OP_A2Y, OP_X2Y: begin
               dst[RI_Y] = 1'b1;
               wdata     = (cmd_op == OP_A2Y) ? a_q : x_q;
               lane      = fl_q.x ? LANE_LO : LANE_ALL;
               nz_src    = wdata;
               nz_wide   = !fl_q.x;
               nz_upd    = 1'b1;
            end
            OP_X2A, OP_Y2A: begin
               dst[RI_A] = 1'b1;
               wdata     = (cmd_op == OP_X2A) ? x_q : y_q;
               if (fl_q.m) begin
                  lane    = LANE_LO;
                  nz_wide = 1'b0;
               end else begin
                  lane    = LANE_ALL;
                  nz_wide = 1'b1;
                  if (fl_q.x) begin
                     wdata[W-1:B] = '0;
                  end
               end
               nz_src = wdata;
               nz_upd = 1'b1;
            end
            OP_A2D, OP_D2A, OP_S2A: begin
               if (cmd_op == OP_A2D) begin
                  dst[RI_D] = 1'b1;
                  wdata     = a_q;
               end else begin
                  dst[RI_A] = 1'b1;
                  wdata     = (cmd_op == OP_D2A) ? d_q : s_q;
               end
               lane    = LANE_ALL;
               nz_src  = wdata;
               nz_wide = 1'b1;
               nz_upd  = 1'b1;
            end
            OP_A2S: begin
               dst[RI_S] = 1'b1;
               lane      = LANE_ALL;
               wdata     = a_q;
            end
            OP_X2S: begin
               dst[RI_S] = 1'b1;
               lane      = LANE_ALL;
               wdata     = fl_q.x ? {STK, x_q[B-1:0]} : x_q;
            end
            OP_SWAP: begin
               dst[RI_A] = 1'b1;
               lane      = LANE_ALL;
               wdata     = {a_q[B-1:0], a_q[W-1:B]};
               nz_src    = wdata;
               nz_wide   = 1'b0;
               nz_upd    = 1'b1;
               cyc       = CW'(CYC_SWAP);
            end
            OP_XCE: begin
               fb.e = fl_q.c;
               fb.c = fl_q.e;
               if (fl_q.c) begin
                  fb.m      = 1'b1;
                  fb.x      = 1'b1;
                  dst[RI_S] = 1'b1;
                  lane      = LANE_HI;
                  wdata     = {STK, {B{1'b0}}};
               end
            end
            OP_LOAD: begin
               cyc = CW'(CYC_LOAD);
               if (int'(cmd_sel) < NREG) begin
                  dst   = NREG'(1) << cmd_sel;
                  lane  = LANE_ALL;
                  wdata = cmd_data;
               end else if (int'(cmd_sel) == SEL_FLAGS) begin
                  fb.c = cmd_data[0];
                  fb.z = cmd_data[1];
                  fb.x = cmd_data[4] | fl_q.e;
                  fb.m = cmd_data[5] | fl_q.e;
                  fb.n = cmd_data[7];
               end
            end
            default: begin
            end
         endcase
         if (dst[RI_S] && fb.e) begin
            wdata[W-1:B] = STK;
         end
      end
   end

   rxu_nz #(.W(W), .B(B)) u_nz (
      .val  (nz_src),
      .wide (nz_wide),
      .n    (nz_n),
      .z    (nz_z)
   );

   always_comb begin
      fl_d = fb;
      if (nz_upd) begin
         fl_d.n = nz_n;
         fl_d.z = nz_z;
      end
   end

endmodule

// File: rtl/rxu_top.sv
module rxu_top
   import rxu_pkg::*;
#(
   parameter int W        = 16,
   parameter int B        = 8,
   parameter int STK_PAGE = 1,
   parameter int CYC_XFER = 2,
   parameter int CYC_SWAP = 3,
   parameter int CYC_LOAD = 1,
   parameter int NB       = W / B,
   parameter int CMAX     = (CYC_SWAP > CYC_XFER) ?
                            ((CYC_SWAP > CYC_LOAD) ? CYC_SWAP : CYC_LOAD) :
                            ((CYC_XFER > CYC_LOAD) ? CYC_XFER : CYC_LOAD),
   parameter int CW       = $clog2(CMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [OPW-1:0]    cmd_op,
   input  logic [SELW-1:0]   cmd_sel,
   input  logic [W-1:0]      cmd_data,
   output logic              rsp_valid,
   output logic [CW-1:0]     rsp_cycles,
   output logic [W-1:0]      obs_a,
   output logic [W-1:0]      obs_x,
   output logic [W-1:0]      obs_y,
   output logic [W-1:0]      obs_s,
   output logic [W-1:0]      obs_d,
   output logic              flag_e,
   output logic              flag_m,
   output logic              flag_x,
   output logic              flag_c,
   output logic              flag_n,
   output logic              flag_z
);

   if (W != 2 * B) begin : g_bad_width
      $error("rxu_top: W must be exactly two bytes of B bits");
   end
   if (B < 8) begin : g_bad_byte
      $error("rxu_top: B must be at least 8 for the status load layout");
   end
   if (STK_PAGE < 0 || STK_PAGE >= (1 << B)) begin : g_bad_page
      $error("rxu_top: STK_PAGE does not fit in one byte");
   end
   if (CYC_XFER < 1 || CYC_SWAP < 1 || CYC_LOAD < 1) begin : g_bad_cyc
      $error("rxu_top: cycle costs must be positive");
   end

   logic [NREG-1:0][W-1:0] rq;
   logic [NREG-1:0]        dst;
   logic [NB-1:0]          lane;
   logic [W-1:0]           wdata;
   rxu_flags_t             fl_q;
   rxu_flags_t             fl_d;
   logic [CW-1:0]          cyc;

   rxu_exec #(
      .W(W), .B(B), .NB(NB), .STK_PAGE(STK_PAGE), .CW(CW),
      .CYC_XFER(CYC_XFER), .CYC_SWAP(CYC_SWAP), .CYC_LOAD(CYC_LOAD)
   ) u_exec (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_sel   (cmd_sel),
      .cmd_data  (cmd_data),
      .a_q       (rq[RI_A]),
      .x_q       (rq[RI_X]),
      .y_q       (rq[RI_Y]),
      .s_q       (rq[RI_S]),
      .d_q       (rq[RI_D]),
      .fl_q      (fl_q),
      .dst       (dst),
      .lane      (lane),
      .wdata     (wdata),
      .fl_d      (fl_d),
      .cyc       (cyc)
   );

   rxu_regfile #(
      .W(W), .B(B), .NB(NB), .STK_PAGE(STK_PAGE)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .dst   (dst),
      .lane  (lane),
      .wdata (wdata),
      .q     (rq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q       <= '{e: 1'b1, m: 1'b1, x: 1'b1, c: 1'b0, n: 1'b0, z: 1'b0};
         rsp_valid  <= 1'b0;
         rsp_cycles <= '0;
      end else begin
         fl_q       <= fl_d;
         rsp_valid  <= cmd_valid;
         rsp_cycles <= cmd_valid ? cyc : '0;
      end
   end

   assign obs_a  = rq[RI_A];
   assign obs_x  = rq[RI_X];
   assign obs_y  = rq[RI_Y];
   assign obs_s  = rq[RI_S];
   assign obs_d  = rq[RI_D];
   assign flag_e = fl_q.e;
   assign flag_m = fl_q.m;
   assign flag_x = fl_q.x;
   assign flag_c = fl_q.c;
   assign flag_n = fl_q.n;
   assign flag_z = fl_q.z;

endmodule

// File: rtl/rxu_checker.sv
module rxu_checker
   import rxu_pkg::*;
#(
   parameter int W        = 16,
   parameter int B        = 8,
   parameter int STK_PAGE = 1,
   parameter int CW       = 2,
   parameter int CYC_SWAP = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic [OPW-1:0]  cmd_op,
   input logic            rsp_valid,
   input logic [CW-1:0]   rsp_cycles,
   input logic [W-1:0]    obs_a,
   input logic [W-1:0]    obs_x,
   input logic [W-1:0]    obs_s,
   input logic            flag_e,
   input logic            flag_m,
   input logic            flag_x,
   input logic            flag_c,
   input logic            flag_n,
   input logic            flag_z
);

   localparam logic [B-1:0] STK = B'(STK_PAGE);

   assert_idx8_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_A2X && flag_x) |=> obs_x[W-1:B] == $past(obs_x[W-1:B]));

   assert_stack_moves_keep_nz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == OP_A2S || cmd_op == OP_X2S)) |=> ($stable(flag_n) && $stable(flag_z)));

   assert_swap_bytes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SWAP) |=> obs_a == {$past(obs_a[B-1:0]), $past(obs_a[W-1:B])});

   assert_exchange_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_XCE) |=> (flag_e == $past(flag_c) && flag_c == $past(flag_e)));

   assert_emu_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_e |-> (flag_m && flag_x));

   assert_emu_stack_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_e |-> obs_s[W-1:B] == STK);

   assert_swap_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SWAP) |=> (rsp_valid && rsp_cycles == CW'(CYC_SWAP)));

   assert_idle_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);

endmodule

bind rxu_top rxu_checker #(
   .W(W), .B(B), .STK_PAGE(STK_PAGE), .CW(CW), .CYC_SWAP(CYC_SWAP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .rsp_valid  (rsp_valid),
   .rsp_cycles (rsp_cycles),
   .obs_a      (obs_a),
   .obs_x      (obs_x),
   .obs_s      (obs_s),
   .flag_e     (flag_e),
   .flag_m     (flag_m),
   .flag_x     (flag_x),
   .flag_c     (flag_c),
   .flag_n     (flag_n),
   .flag_z     (flag_z)
);

// File: tb/rxu_top_tb.sv
module rxu_top_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic [3:0]  cmd_op;
   logic [2:0]  cmd_sel;
   logic [15:0] cmd_data;
   logic        rsp_valid;
   logic [1:0]  rsp_cycles;
   logic [15:0] obs_a, obs_x, obs_y, obs_s, obs_d;
   logic        flag_e, flag_m, flag_x, flag_c, flag_n, flag_z;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   // reference state
   logic [15:0] ma, mx, my, ms, md;
   bit fe, fm, fx, fc, fn, fz;
   bit erv;
   int ecyc;

   always #5 clk = ~clk;

   rxu_top u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sel(cmd_sel), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
      .rsp_cycles(rsp_cycles), .obs_a(obs_a), .obs_x(obs_x), .obs_y(obs_y),
      .obs_s(obs_s), .obs_d(obs_d), .flag_e(flag_e), .flag_m(flag_m),
      .flag_x(flag_x), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string tag_of(int op, bit valid);
      if (!valid) return "R9";
      case (op)
         1, 2, 7, 10, 12: return "R2";
         8, 11:           return "R3";
         4, 9:            return "R4";
         3, 5, 6:         return "R5";
         13:              return "R6";
         14:              return "R7";
         15:              return "R10";
         default:         return "R9";
      endcase
   endfunction

   task automatic compare(string tag);
      chk(tag, "A", int'(obs_a), int'(ma));
      chk(tag, "X", int'(obs_x), int'(mx));
      chk(tag, "Y", int'(obs_y), int'(my));
      chk(tag, "S", int'(obs_s), int'(ms));
      chk(tag, "D", int'(obs_d), int'(md));
      chk(tag, "e", int'(flag_e), int'(fe));
      chk(tag, "m", int'(flag_m), int'(fm));
      chk(tag, "x", int'(flag_x), int'(fx));
      chk(tag, "c", int'(flag_c), int'(fc));
      chk("R8", "n", int'(flag_n), int'(fn));
      chk("R8", "z", int'(flag_z), int'(fz));
      chk("R9", "rsp_valid", int'(rsp_valid), int'(erv));
      chk("R9", "rsp_cycles", int'(rsp_cycles), ecyc);
   endtask

   task automatic nz8(logic [15:0] v);
      fn = v[7];
      fz = (v[7:0] == 8'h00);
   endtask

   task automatic nz16(logic [15:0] v);
      fn = v[15];
      fz = (v == 16'h0000);
   endtask

   // behavioural reference for one command
   task automatic model(int op, int sel, logic [15:0] data);
      logic [15:0] src;
      bit t;
      erv  = 1;
      ecyc = 2;
      case (op)
         1, 7, 12: begin
            src = (op == 1) ? ma : (op == 7) ? ms : my;
            if (fx) begin mx[7:0] = src[7:0]; nz8(mx); end
            else    begin mx = src; nz16(mx); end
         end
         2, 10: begin
            src = (op == 2) ? ma : mx;
            if (fx) begin my[7:0] = src[7:0]; nz8(my); end
            else    begin my = src; nz16(my); end
         end
         8, 11: begin
            src = (op == 8) ? mx : my;
            if (fm)      begin ma[7:0] = src[7:0]; nz8(ma); end
            else if (fx) begin ma = {8'h00, src[7:0]}; nz16(ma); end
            else         begin ma = src; nz16(ma); end
         end
         3: begin md = ma; nz16(md); end
         5: begin ma = md; nz16(ma); end
         6: begin ma = ms; nz16(ma); end
         4: ms = ma;
         9: ms = fx ? {8'h01, mx[7:0]} : mx;
         13: begin ecyc = 3; ma = {ma[7:0], ma[15:8]}; nz8(ma); end
         14: begin
            t = fe; fe = fc; fc = t;
            if (fe) begin fm = 1; fx = 1; end
         end
         15: begin
            ecyc = 1;
            case (sel)
               0: ma = data;
               1: mx = data;
               2: my = data;
               3: ms = data;
               4: md = data;
               5: begin
                  fc = data[0]; fz = data[1]; fx = data[4];
                  fm = data[5]; fn = data[7];
               end
               default: ;
            endcase
         end
         default: ;
      endcase
      if (fe) begin
         fm = 1; fx = 1;
         ms[15:8] = 8'h01;
      end
   endtask

   task automatic step(int op, int sel, logic [15:0] data);
      cmd_valid = 1'b1;
      cmd_op    = 4'(op);
      cmd_sel   = 3'(sel);
      cmd_data  = data;
      model(op, sel, data);
      @(negedge clk);
      compare(tag_of(op, 1'b1));
   endtask

   task automatic idle();
      cmd_valid = 1'b0;
      cmd_op    = 4'(13);
      erv  = 0;
      ecyc = 0;
      @(negedge clk);
      compare("R9");
   endtask

   initial begin
      logic [15:0] pat [5];
      pat[0] = 16'h8000; pat[1] = 16'h0080; pat[2] = 16'hFF00;
      pat[3] = 16'h0000; pat[4] = 16'h7F01;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sel = '0; cmd_data = '0;
      ma = 0; mx = 0; my = 0; md = 0; ms = 16'h01FF;
      fe = 1; fm = 1; fx = 1; fc = 0; fn = 0; fz = 0; erv = 0; ecyc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R7: leave emulation (carry 0 in), then exercise every width mode
      step(14, 0, 16'h0);
      for (int mode = 0; mode < 4; mode++) begin
         for (int p = 0; p < 5; p++) begin
            step(15, 5, 16'((mode & 2) << 4 | (mode & 1) << 4));
            step(15, 0, pat[p]);
            step(15, 1, pat[(p + 1) % 5]);
            step(15, 2, pat[(p + 2) % 5]);
            step(15, 3, pat[(p + 3) % 5]);
            step(15, 4, pat[(p + 4) % 5]);
            for (int op = 0; op < 14; op++) begin
               step(op, 0, 16'h0);
            end
            idle();
         end
      end

      // R7: enter emulation, then stack writes and status load while in it
      step(15, 3, 16'h3456);
      step(15, 5, 16'h0001);
      step(14, 0, 16'h0);
      step(15, 3, 16'hABCD);
      step(15, 0, 16'h9977);
      step(4, 0, 16'h0);
      step(15, 5, 16'h0000);
      step(14, 0, 16'h0);
      step(14, 0, 16'h0);
      step(15, 6, 16'hFFFF);
      step(15, 7, 16'hFFFF);

      // mixed traffic
      for (int i = 0; i < 800; i++) begin
         if (($urandom % 8) == 0) idle();
         else step(int'($urandom % 16), int'($urandom % 8), 16'($urandom));
      end
      idle();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule